// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

A register-mapped timer that counts a 32-bit value down to zero at a rate set by a power-of-two prescaler, then requests an interrupt that carries an 8-bit vector. Software programs a control word (vector, mask, run mode), a divide code and an initial count. It can read the live count at any time. Writing the initial count is the start and stop control: a nonzero value loads the counter and starts it, and zero halts it.

In one-shot mode the counter stops at zero after a single expiry. In periodic mode it reloads the initial count at each expiry and runs on. The mask bit gates only the interrupt request, so a masked timer keeps counting. A pending request is held, and is visible as a status bit in the control word, until the consumer pulses the acknowledge input.

The bus is a single-cycle write strobe with a combinational read path. There are four 32-bit word slots, and the byte address must be word aligned.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the control slot (byte 0x0) reads 0x0001_0000, which is masked, one-shot and vector 0. The initial-count slot (0x4), the current-count slot (0x8) and the divide slot (0xC) read 0, and `irq_req` is low.
- R2: The control word has these fields: vector in bits [7:0], a read-only pending status in bit 12 (1 = request outstanding), mask in bit 16, and run mode in bits [18:17] (0 = one-shot, 1 = periodic). Every other bit reads 0, and `irq_vector` always shows the stored vector.
- R3: A control write whose mode field is 2 or 3 leaves the stored mode unchanged. The write still updates the vector and the mask.
- R4: Divide codes map to prescale ratios as follows: 0xB=1, 0x0=2, 0x1=4, 0x2=8, 0x3=16, 0x8=32, 0x9=64 and 0xA=128. An unmasked start with count N raises `irq_req` exactly N×ratio clock edges after the edge that accepted the initial-count write.
- R5: The divide code uses only bits 3, 1 and 0. Its other bits are dropped on write and read back as 0 (a write of 0xF reads 0xB, and a write of 0x4 behaves and reads as 0x0).
- R6: A nonzero initial-count write loads the current count with that value on the write edge and starts counting. The current-count slot then returns the live value, which falls by one per prescaled period.
- R7: A zero initial-count write sets the current count to 0 and stops the counter. No later interrupt occurs.
- R8: In one-shot mode the count stays at 0 after expiry, and no further request occurs until the initial count is written again.
- R9: In periodic mode the counter goes from 1 back to the initial count at each expiry and keeps counting.
- R10: With mask = 1, an expiry raises no request, and the count still decrements and reloads.
- R11: A request stays asserted, with status bit 12 set, until an edge samples `irq_ack` high. After that edge `irq_req` and the status bit are both 0.
- R12: When an unmasked expiry and `irq_ack` fall on the same edge, the request remains asserted.
- R13: Writes to the current-count slot, and writes to any address whose low two bits are nonzero, change no register.
- R14: A divide write during counting takes effect at the next prescaler boundary, so the period in progress finishes at the old ratio. An initial-count write restarts the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (4) | Byte address of the word slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_req | output | 1 | Interrupt request, held until acknowledged |
| irq_vector | output | VEC_W (8) | Vector carried with the request |
| irq_ack | input | 1 | Acknowledge, clears the pending request |

## Verification
Two functions can meet on one edge: expiry of a periodic count, and the consumer's acknowledge of the earlier request. The bench starts a periodic count of 4 at ratio 1 and acknowledges the first request one edge after it appears. It then raises `irq_ack` so that the acknowledge lands on exactly the edge of the second expiry. The result is judged correct only if `irq_req` and status bit 12 are still 1 after that edge and the count has reloaded to 4. A second collision, between a divide write and a running prescaler period, is judged by the exact live count some cycles later.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // word slots, selected by byte address bits [3:2]
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_INIT = 1;
    localparam int SLOT_CUR  = 2;
    localparam int SLOT_DIV  = 3;

    // control word bit positions
    localparam int CTRL_STAT_BIT = 12;
    localparam int CTRL_MASK_BIT = 16;
    localparam int CTRL_MODE_LSB = 17;

    localparam logic [1:0] MODE_ONCE   = 2'd0;
    localparam logic [1:0] MODE_REPEAT = 2'd1;

    // prescaler: the ratio is 2**shift with shift in 0..7
    localparam int SHIFT_W = 3;
    localparam int PRE_W   = 7;

    // packed divide code {c3,c1,c0}; 3'b111 = divide by 1, then 2,4,...,128
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [2:0] packed_code);
        return packed_code + 3'd1;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int VEC_W  = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              pend,
    input  logic [CNT_W-1:0]  cur_cnt,
    output logic [31:0]       rdata,
    output logic [VEC_W-1:0]  vec,
    output logic              masked,
    output logic              periodic,
    output logic [2:0]        div_code,
    output logic [CNT_W-1:0]  init_val,
    output logic              init_wr,
    output logic [CNT_W-1:0]  init_wdata
);

    localparam int SLOT_W = ADDR_W - 2;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             mask;
        logic             periodic;
        logic [2:0]       div;
        logic [CNT_W-1:0] init;
    } regs_t;

    regs_t r_d, r_q;

    logic [SLOT_W-1:0] slot;
    logic              aligned;
    logic              wr_ctrl, wr_init, wr_div;

    assign slot    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign wr_ctrl = wr_en && aligned && (slot == SLOT_W'(SLOT_CTRL));
    assign wr_init = wr_en && aligned && (slot == SLOT_W'(SLOT_INIT));
    assign wr_div  = wr_en && aligned && (slot == SLOT_W'(SLOT_DIV));

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.vec  = wdata[VEC_W-1:0];
            r_d.mask = wdata[CTRL_MASK_BIT];
            if (wdata[CTRL_MODE_LSB+1:CTRL_MODE_LSB] == MODE_ONCE) begin
                r_d.periodic = 1'b0;
            end else if (wdata[CTRL_MODE_LSB+1:CTRL_MODE_LSB] == MODE_REPEAT) begin
                r_d.periodic = 1'b1;
            end
        end
        if (wr_init) begin
            r_d.init = wdata[CNT_W-1:0];
        end
        if (wr_div) begin
            r_d.div = {wdata[3], wdata[1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{vec: '0, mask: 1'b1, periodic: 1'b0, div: 3'b000, init: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (slot)
                SLOT_W'(SLOT_CTRL): begin
                    rdata[VEC_W-1:0]                       = r_q.vec;
                    rdata[CTRL_STAT_BIT]                   = pend;
                    rdata[CTRL_MASK_BIT]                   = r_q.mask;
                    rdata[CTRL_MODE_LSB+1:CTRL_MODE_LSB]   = {1'b0, r_q.periodic};
                end
                SLOT_W'(SLOT_INIT): rdata = 32'(r_q.init);
                SLOT_W'(SLOT_CUR):  rdata = 32'(cur_cnt);
                SLOT_W'(SLOT_DIV):  rdata = {28'd0, r_q.div[2], 1'b0, r_q.div[1:0]};
                default:            rdata = '0;
            endcase
        end
    end

    assign vec        = r_q.vec;
    assign masked     = r_q.mask;
    assign periodic   = r_q.periodic;
    assign div_code   = r_q.div;
    assign init_val   = r_q.init;
    assign init_wr    = wr_init;
    assign init_wdata = wdata[CNT_W-1:0];

    // an unsupported mode code must not disturb the stored mode
    assert_mode_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[CTRL_MODE_LSB+1]) |=> $stable(periodic))
        else $error("mode changed by reserved code");

    // the current-count slot has no writable state behind it
    assert_cur_slot_ro_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ctrl && !wr_init && !wr_div) |=> $stable(r_q))
        else $error("register changed by ignored write");

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] div_code,
    output logic       tick
);

    typedef struct packed {
        logic [PRE_W-1:0]   phase;
        logic [SHIFT_W-1:0] shift;
    } pre_t;

    pre_t p_d, p_q;

    logic [PRE_W-1:0] limit;

    assign limit = PRE_W'((32'd1 << p_q.shift) - 32'd1);
    assign tick  = run && !restart && (p_q.phase == limit);

    always_comb begin
        p_d = p_q;
        if (restart || !run || tick) begin
            // phase restarts and a new ratio is adopted only at a boundary
            p_d.phase = '0;
            p_d.shift = div_shift(div_code);
        end else begin
            p_d.phase = p_q.phase + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '{phase: '0, shift: div_shift(3'b000)};
        end else begin
            p_q <= p_d;
        end
    end

    assert_phase_step_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !tick) |=> (p_q.phase == $past(p_q.phase) + PRE_W'(1))
                                     && $stable(p_q.shift))
        else $error("prescaler phase or ratio moved inside a period");

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] init_val,
    input  logic             periodic,
    input  logic             tick,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             running,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } cnt_t;

    cnt_t c_d, c_q;

    logic last_step;

    assign last_step = (c_q.cnt == CNT_W'(1));
    assign expire    = tick && c_q.run && last_step && !init_wr;

    always_comb begin
        c_d = c_q;
        if (init_wr) begin
            c_d.cnt = wr_val;
            c_d.run = (wr_val != '0);
        end else if (tick && c_q.run) begin
            if (last_step) begin
                if (periodic) begin
                    c_d.cnt = init_val;
                end else begin
                    c_d.cnt = '0;
                    c_d.run = 1'b0;
                end
            end else begin
                c_d.cnt = c_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{cnt: '0, run: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign cur_cnt = c_q.cnt;
    assign running = c_q.run;

    assert_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && running && !init_wr && !last_step) |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)))
        else $error("count did not decrement on a tick");

    assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_wr && wr_val == '0) |=> (cur_cnt == '0) && !running)
        else $error("zero write did not stop the counter");

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !init_wr) |=> $stable(cur_cnt) && !running)
        else $error("idle counter moved");

    assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> (cur_cnt == $past(init_val)) && running)
        else $error("periodic reload missing");

endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int VEC_W  = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector,
    input  logic              irq_ack
);

    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t i_d, i_q;

    logic [VEC_W-1:0] vec;
    logic             masked, periodic;
    logic [2:0]       div_code;
    logic [CNT_W-1:0] init_val, init_wdata, cur_cnt;
    logic             init_wr, running, tick, expire;

    tmr_regs #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .pend       (i_q.pend),
        .cur_cnt    (cur_cnt),
        .rdata      (bus_rdata),
        .vec        (vec),
        .masked     (masked),
        .periodic   (periodic),
        .div_code   (div_code),
        .init_val   (init_val),
        .init_wr    (init_wr),
        .init_wdata (init_wdata)
    );

    tmr_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .restart  (init_wr),
        .div_code (div_code),
        .tick     (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_wr  (init_wr),
        .wr_val   (init_wdata),
        .init_val (init_val),
        .periodic (periodic),
        .tick     (tick),
        .cur_cnt  (cur_cnt),
        .running  (running),
        .expire   (expire)
    );

    always_comb begin
        i_d = i_q;
        if (expire && !masked) begin
            i_d.pend = 1'b1;          // a fresh expiry wins over an acknowledge
        end else if (irq_ack) begin
            i_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q <= '{pend: 1'b0};
        end else begin
            i_q <= i_d;
        end
    end

    assign irq_req    = i_q.pend;
    assign irq_vector = vec;

    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req)
        else $error("request dropped without acknowledge");

    assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && masked && !irq_req) |=> !irq_req)
        else $error("masked expiry raised a request");

    assert_expire_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !masked) |=> irq_req)
        else $error("unmasked expiry lost");

endmodule

// File: tb/sim_irq_countdown_timer.sv
module sim_irq_countdown_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [7:0]  irq_vector;
    logic        irq_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_countdown_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_req    (irq_req),
        .irq_vector (irq_vector),
        .irq_ack    (irq_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // all bus tasks start and end just after a falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic wait_irq(input int limit, output int n);
        n = 0;
        while (!irq_req && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic int ratio_of(input logic [3:0] code);
        case (code & 4'hB)
            4'hB: return 1;
            4'h0: return 2;
            4'h1: return 4;
            4'h2: return 8;
            4'h3: return 16;
            4'h8: return 32;
            4'h9: return 64;
            4'hA: return 128;
            default: return 0;
        endcase
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v); check("R1 ctrl", v, 32'h0001_0000);
        rd(4'h4, v); check("R1 init", v, 32'h0);
        rd(4'h8, v); check("R1 cur", v, 32'h0);
        rd(4'hC, v); check("R1 div", v, 32'h0);
        check("R1 irq", 32'(irq_req), 32'h0);
    endtask

    task automatic t_ctrl_fields();
        logic [31:0] v;
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R2 R3 all-ones ctrl", v, 32'h0001_00FF);
        check("R2 vector pin", 32'(irq_vector), 32'hFF);
        wr(4'h0, 32'h0002_005A);
        rd(4'h0, v); check("R2 periodic ctrl", v, 32'h0002_005A);
        wr(4'h0, 32'h0004_0033);
        rd(4'h0, v); check("R3 reserved mode", v, 32'h0002_0033);
        wr(4'h0, 32'h0001_0000);
    endtask

    task automatic t_div_fields();
        logic [31:0] v;
        wr(4'hC, 32'h0000_000F);
        rd(4'hC, v); check("R5 div 0xF", v, 32'hB);
        wr(4'hC, 32'h0000_0004);
        rd(4'hC, v); check("R5 div 0x4", v, 32'h0);
    endtask

    task automatic t_prescale();
        logic [3:0] codes [7] = '{4'hB, 4'h0, 4'h1, 4'h2, 4'h8, 4'hA, 4'h4};
        int         counts[7] = '{5, 3, 2, 2, 1, 1, 3};
        int n;
        wr(4'h0, 32'h0000_0042);
        for (int i = 0; i < 7; i++) begin
            wr(4'hC, 32'(codes[i]));
            wr(4'h4, 32'(counts[i]));
            wait_irq(counts[i] * ratio_of(codes[i]) + 8, n);
            check($sformatf("R4 R5 expiry code 0x%0h", codes[i]), 32'(n),
                  32'(counts[i] * ratio_of(codes[i])));
            check("R2 vector with request", 32'(irq_vector), 32'h42);
            ack();
        end
    endtask

    task automatic t_live_and_stop();
        logic [31:0] v;
        bit seen = 0;
        wr(4'h0, 32'h0000_0042);
        wr(4'hC, 32'h0000_000B);
        wr(4'h4, 32'd20);
        repeat (5) @(negedge clk);
        rd(4'h8, v); check("R6 live count", v, 32'd15);
        wr(4'h8, 32'd7);
        rd(4'h8, v); check("R13 cur write ignored", v, 32'd14);
        wr(4'h5, 32'd9);
        rd(4'h4, v); check("R13 misaligned init", v, 32'd20);
        rd(4'h8, v); check("R13 misaligned cur", v, 32'd13);
        wr(4'h4, 32'd0);
        rd(4'h8, v); check("R7 stopped count", v, 32'd0);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (irq_req) seen = 1;
        end
        check("R7 no request after stop", 32'(seen), 32'h0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        int n;
        bit seen = 0;
        wr(4'h0, 32'h0000_0042);
        wr(4'hC, 32'h0000_000B);
        wr(4'h4, 32'd3);
        wait_irq(20, n);
        check("R4 one-shot expiry", 32'(n), 32'd3);
        rd(4'h0, v); check("R11 status pending", v, 32'h0000_1042);
        repeat (5) @(negedge clk);
        check("R11 request held", 32'(irq_req), 32'h1);
        rd(4'h8, v); check("R8 count at zero", v, 32'd0);
        ack();
        check("R11 request cleared", 32'(irq_req), 32'h0);
        rd(4'h0, v); check("R11 status idle", v, 32'h0000_0042);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (irq_req) seen = 1;
        end
        check("R8 no second request", 32'(seen), 32'h0);
        rd(4'h8, v); check("R8 count stays zero", v, 32'd0);
    endtask

    task automatic t_periodic_collide();
        logic [31:0] v;
        int n;
        wr(4'h0, 32'h0002_0042);
        wr(4'hC, 32'h0000_000B);
        wr(4'h4, 32'd4);
        wait_irq(20, n);
        check("R9 first period", 32'(n), 32'd4);
        rd(4'h8, v); check("R9 reload value", v, 32'd4);
        ack();
        check("R11 ack clears", 32'(irq_req), 32'h0);
        rd(4'h8, v); check("R9 counting on", v, 32'd3);
        repeat (2) @(negedge clk);
        ack();   // lands on the second expiry edge
        check("R12 request survives ack", 32'(irq_req), 32'h1);
        rd(4'h0, v); check("R12 status pending", v, 32'h0002_1042);
        rd(4'h8, v); check("R9 second reload", v, 32'd4);
        ack();
        wr(4'h4, 32'd0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        int n;
        bit seen = 0;
        wr(4'h0, 32'h0003_0000);
        wr(4'hC, 32'h0000_000B);
        wr(4'h4, 32'd5);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (irq_req) seen = 1;
        end
        check("R10 masked no request", 32'(seen), 32'h0);
        rd(4'h8, v); check("R10 counting while masked", v, 32'd3);
        wr(4'h0, 32'h0002_0000);
        wait_irq(20, n);
        check("R10 unmasked expiry timing", 32'(n), 32'd2);
        ack();
        wr(4'h4, 32'd0);
    endtask

    task automatic t_div_switch();
        logic [31:0] v;
        wr(4'h0, 32'h0001_0000);
        wr(4'hC, 32'h0000_0003);
        wr(4'h4, 32'd100);
        repeat (4) @(negedge clk);
        wr(4'hC, 32'h0000_000B);
        repeat (15) @(negedge clk);
        rd(4'h8, v); check("R14 divide at boundary", v, 32'd95);
        wr(4'h4, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_fields();
        t_div_fields();
        t_prescale();
        t_live_and_stop();
        t_oneshot();
        t_periodic_collide();
        t_mask();
        t_div_switch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule